// File: doc/BRIEF.md
# DMA Channel Masked-Write Register File

This block is the register front end of a single descriptor-driven DMA channel. Software reaches it over a 32-bit register bus. The bus address counts 32-bit words, so a byte offset divided by four gives the word index. The block holds a 16-bit channel status word, an upper and a lower command pointer, and three condition selectors.

Writes to the channel control register use a mask-and-value format. The upper half of the write data selects which status bits may change, and the lower half supplies their new values. Software can therefore start, pause or stop the channel, or adjust device bits, without a read-modify-write sequence.

The low byte of the status word holds device-dependent flags. Both software and the attached device can update these flags. Each selector compares them, through its own mask, against a programmed value. The result drives three condition flags that the descriptor engine uses to decide whether to interrupt, branch or wait. The descriptor engine itself is not part of this block; it consumes the condition flags and the command pointer.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the status word, both command pointers and all three selectors read as zero. With every selector at zero, all three condition outputs are 1, because zero compared to zero is a match.
- R2: A write to word 0 (byte offset 0x00) updates status bit i to write-data bit i only when write-data bit 16+i is 1. Every status bit whose mask bit is 0 keeps its value. Bits 9 and 8 are reserved and always read 0.
- R3: A read of word 1 (byte offset 0x04) returns the 16-bit status word in bits 15..0 and zero in bits 31..16. The status bit positions are RUN 15, PAUSE 14, FLUSH 13, WAKE 12, DEAD 11, ACTIVE 10 and device flags 7..0.
- R4: ACTIVE (bit 10) reads 1 exactly when RUN is 1 and PAUSE is 0. Software cannot write it. A control write that clears RUN makes ACTIVE read 0 from the following cycle.
- R5: For each device flag i in 7..0, a high dev_set_en[i] loads dev_set_val[i] into status bit i on the clock edge. This load takes priority over a software control write to the same bit in the same cycle.
- R6: A write to word 3 (byte offset 0x0C) stores the command pointer with bits 3..0 forced to 0, because descriptors are 16 bytes. A write to word 2 (byte offset 0x08) stores all 32 bits of the upper pointer. Both registers read back through their own word.
- R7: Words 4, 5 and 6 (byte offsets 0x10, 0x14, 0x18) are the interrupt, branch and wait selectors. Each keeps an 8-bit mask from bits 23..16 and an 8-bit value from bits 7..0, and reads back with every other bit zero.
- R8: Each condition output is 1 exactly when the device flags ANDed with that selector's mask equal that selector's value. The output is combinational from registered state.
- R9: Writes to word 1 and to words 7 and above change no register. Reads of word 0 and of words 7 and above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Word index of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| dev_set_en | input | 8 | Per-bit load enables for device flags from the device |
| dev_set_val | input | 8 | Device flag values loaded where enabled |
| status_o | output | 16 | Current channel status word |
| cmd_ptr_o | output | 32 | Command pointer, 16-byte aligned |
| cmd_ptr_hi_o | output | 32 | Upper command pointer |
| irq_cond | output | 1 | Interrupt selector match |
| brn_cond | output | 1 | Branch selector match |
| wait_cond | output | 1 | Wait selector match |

## Verification
A software control write and a hardware device-flag load can land on the same status bits in the same clock edge. The random phase draws both in independent cycles, so they often coincide, and a directed step forces them to overlap on part of the low byte. The bench judges the outcome with a bit-by-bit reference model. That model applies the software mask first and the hardware enables afterwards. A mismatch in any bit, whether or not that bit is covered by a hardware enable, is reported against the priority requirement or the masked-update requirement.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
  localparam int STAT_W   = 16;
  localparam int DEV_W    = 8;
  localparam int NUM_SEL  = 3;

  localparam int W_CTRL   = 0;
  localparam int W_STATUS = 1;
  localparam int W_PTR_HI = 2;
  localparam int W_PTR    = 3;
  localparam int W_SEL0   = 4;
  localparam int W_LAST   = W_SEL0 + NUM_SEL - 1;

  localparam int B_RUN    = 15;
  localparam int B_PAUSE  = 14;
  localparam int B_ACTIVE = 10;

  // bits software may change: run-state flags except ACTIVE, plus device byte
  localparam logic [STAT_W-1:0] SW_WRITABLE = 16'hF8FF;

  function automatic logic [STAT_W-1:0] merge_masked(
    input logic [STAT_W-1:0] old_v,
    input logic [STAT_W-1:0] sel,
    input logic [STAT_W-1:0] new_v);
    return (old_v & ~sel) | (new_v & sel);
  endfunction

  function automatic logic sel_hit(
    input logic [DEV_W-1:0] dev,
    input logic [DEV_W-1:0] msk,
    input logic [DEV_W-1:0] val);
    return (dev & msk) == val;
  endfunction
endpackage

// File: rtl/dmacr_status.sv
module dmacr_status
  import dmacr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_mask,
  input  logic [STAT_W-1:0] sw_val,
  input  logic [DEV_W-1:0]  hw_en,
  input  logic [DEV_W-1:0]  hw_val,
  output logic [STAT_W-1:0] status
);
  logic [STAT_W-1:0] held_q;
  logic [STAT_W-1:0] sw_sel;
  logic [STAT_W-1:0] after_sw;
  logic [STAT_W-1:0] after_hw;
  logic              active;

  always_comb begin
    sw_sel   = sw_we ? (sw_mask & SW_WRITABLE) : '0;
    after_sw = merge_masked(held_q, sw_sel, sw_val);
    // device load applied last so it wins on shared bits
    after_hw = after_sw;
    after_hw[DEV_W-1:0] = (after_sw[DEV_W-1:0] & ~hw_en) | (hw_val & hw_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= after_hw & SW_WRITABLE;
  end

  assign active = held_q[B_RUN] & ~held_q[B_PAUSE];

  always_comb begin
    status           = held_q;
    status[B_ACTIVE] = active;
  end
endmodule

// File: rtl/dmacr_selector.sv
module dmacr_selector
  import dmacr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [31:0]      wdata,
  input  logic [DEV_W-1:0] dev,
  output logic             hit,
  output logic [31:0]      rdata
);
  logic [DEV_W-1:0] msk_q;
  logic [DEV_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= '0;
      val_q <= '0;
    end else if (we) begin
      msk_q <= wdata[16 +: DEV_W];
      val_q <= wdata[0 +: DEV_W];
    end
  end

  assign hit   = sel_hit(dev, msk_q, val_q);
  assign rdata = {{(16-DEV_W){1'b0}}, msk_q, {(16-DEV_W){1'b0}}, val_q};
endmodule

// File: rtl/dmacr_cmdptr.sv
module dmacr_cmdptr #(
  parameter int DESC_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_lo,
  input  logic        we_hi,
  input  logic [31:0] wdata,
  output logic [31:0] ptr,
  output logic [31:0] ptr_hi
);
  localparam int ALIGN_BITS = $clog2(DESC_BYTES);
  localparam logic [31:0] ALIGN_MASK = ~((32'd1 << ALIGN_BITS) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      ptr_hi <= '0;
    end else begin
      if (we_lo) ptr    <= wdata & ALIGN_MASK;
      if (we_hi) ptr_hi <= wdata;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmacr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [DEV_W-1:0]  dev_set_en,
  input  logic [DEV_W-1:0]  dev_set_val,
  output logic [STAT_W-1:0] status_o,
  output logic [31:0]       cmd_ptr_o,
  output logic [31:0]       cmd_ptr_hi_o,
  output logic              irq_cond,
  output logic              brn_cond,
  output logic              wait_cond
);
  // named decode events, also observed by the checker
  logic               ctrl_wr;
  logic               ptr_wr;
  logic               ptr_hi_wr;
  logic               unmapped_wr;
  logic [NUM_SEL-1:0] sel_wr;
  logic [NUM_SEL-1:0] sel_hit_v;
  logic [31:0]        sel_rd [NUM_SEL];
  logic [31:0]        addr_w;

  assign addr_w      = 32'(reg_addr);
  assign ctrl_wr     = reg_we && (addr_w == W_CTRL);
  assign ptr_wr      = reg_we && (addr_w == W_PTR);
  assign ptr_hi_wr   = reg_we && (addr_w == W_PTR_HI);
  assign unmapped_wr = reg_we && ((addr_w == W_STATUS) || (addr_w > W_LAST));

  dmacr_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_we   (ctrl_wr),
    .sw_mask (reg_wdata[31:16]),
    .sw_val  (reg_wdata[15:0]),
    .hw_en   (dev_set_en),
    .hw_val  (dev_set_val),
    .status  (status_o)
  );

  dmacr_cmdptr #(.DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_lo  (ptr_wr),
    .we_hi  (ptr_hi_wr),
    .wdata  (reg_wdata),
    .ptr    (cmd_ptr_o),
    .ptr_hi (cmd_ptr_hi_o)
  );

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign sel_wr[g] = reg_we && (addr_w == W_SEL0 + g);
    dmacr_selector u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sel_wr[g]),
      .wdata (reg_wdata),
      .dev   (status_o[DEV_W-1:0]),
      .hit   (sel_hit_v[g]),
      .rdata (sel_rd[g])
    );
  end

  assign irq_cond  = sel_hit_v[0];
  assign brn_cond  = sel_hit_v[1];
  assign wait_cond = sel_hit_v[2];

  always_comb begin
    reg_rdata = '0;
    if (addr_w == W_STATUS)      reg_rdata = {16'h0, status_o};
    else if (addr_w == W_PTR_HI) reg_rdata = cmd_ptr_hi_o;
    else if (addr_w == W_PTR)    reg_rdata = cmd_ptr_o;
    else begin
      for (int i = 0; i < NUM_SEL; i++)
        if (addr_w == W_SEL0 + i) reg_rdata = sel_rd[i];
    end
  end
endmodule

// File: rtl/dmacr_checker.sv
module dmacr_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [7:0]        dev_set_en,
  input logic [7:0]        dev_set_val,
  input logic [15:0]       status_o,
  input logic [31:0]       cmd_ptr_o,
  input logic [31:0]       cmd_ptr_hi_o,
  input logic              irq_cond,
  input logic              ctrl_wr,
  input logic              ptr_wr,
  input logic              unmapped_wr
);
  // R2: bits outside the write mask keep their value (ACTIVE excluded)
  a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && dev_set_en == 8'h00) |=>
      ((status_o & ~$past(reg_wdata[31:16]) & 16'hFBFF) ==
       ($past(status_o) & ~$past(reg_wdata[31:16]) & 16'hFBFF)));

  // R4: clearing RUN drops ACTIVE on the next cycle
  a_r4_run_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[31] && !reg_wdata[15]) |=> !status_o[10]);

  // R5: device load wins on every enabled bit
  a_r5_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_set_en != 8'h00) |=>
      ((status_o[7:0] & $past(dev_set_en)) == ($past(dev_set_val) & $past(dev_set_en))));

  // R6: command pointer stores the aligned write data
  a_r6_ptr_align: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (cmd_ptr_o == {$past(reg_wdata[31:4]), 4'h0}));

  // R8: interrupt condition agrees with the selector read back on the bus
  a_r8_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(4)) |->
      (irq_cond == ((status_o[7:0] & reg_rdata[23:16]) == reg_rdata[7:0])));

  // R9: ignored writes leave state untouched
  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped_wr && dev_set_en == 8'h00) |=>
      ($stable(status_o) && $stable(cmd_ptr_o) && $stable(cmd_ptr_hi_o)));
endmodule

bind dma_chan_regs dmacr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .dev_set_en   (dev_set_en),
  .dev_set_val  (dev_set_val),
  .status_o     (status_o),
  .cmd_ptr_o    (cmd_ptr_o),
  .cmd_ptr_hi_o (cmd_ptr_hi_o),
  .irq_cond     (irq_cond),
  .ctrl_wr      (ctrl_wr),
  .ptr_wr       (ptr_wr),
  .unmapped_wr  (unmapped_wr)
);

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  dev_set_en = '0;
  logic [7:0]  dev_set_val = '0;
  logic [15:0] status_o;
  logic [31:0] cmd_ptr_o, cmd_ptr_hi_o;
  logic        irq_cond, brn_cond, wait_cond;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] m_ctl;
  logic [31:0] m_ptr, m_hi;
  logic [7:0]  m_smask [3];
  logic [7:0]  m_sval  [3];

  always #2.5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_set_en(dev_set_en),
    .dev_set_val(dev_set_val), .status_o(status_o), .cmd_ptr_o(cmd_ptr_o),
    .cmd_ptr_hi_o(cmd_ptr_hi_o), .irq_cond(irq_cond), .brn_cond(brn_cond),
    .wait_cond(wait_cond)
  );

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s = m_ctl & 16'hF8FF;
    s[10] = s[15] && !s[14];
    return s;
  endfunction

  function automatic logic exp_cond(int k);
    logic [7:0] d;
    d = exp_status() & 16'h00FF;
    return ~|((d & m_smask[k]) ^ m_sval[k]);
  endfunction

  function automatic logic [31:0] exp_read(int a);
    case (a)
      1: return {16'h0, exp_status()};
      2: return m_hi;
      3: return m_ptr;
      4, 5, 6: return {8'h0, m_smask[a-4], 8'h0, m_sval[a-4]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update(input bit we, input int a, input logic [31:0] d,
                              input logic [7:0] hen, input logic [7:0] hval);
    if (we) begin
      if (a == 0) begin
        for (int i = 0; i < 16; i++)
          if (d[16+i] && i != 10 && i != 9 && i != 8) m_ctl[i] = d[i];
      end else if (a == 2) m_hi = d;
      else if (a == 3) m_ptr = {d[31:4], 4'h0};
      else if (a >= 4 && a <= 6) begin
        m_smask[a-4] = d[23:16];
        m_sval[a-4]  = d[7:0];
      end
    end
    for (int i = 0; i < 8; i++)
      if (hen[i]) m_ctl[i] = hval[i];
  endtask

  task automatic check_outputs();
    logic [15:0] es;
    es = exp_status();
    check(status_o === es, "R2/R4/R5 status", {16'h0, status_o}, {16'h0, es});
    check(cmd_ptr_o === m_ptr && cmd_ptr_hi_o === m_hi, "R6 pointers",
          cmd_ptr_o, m_ptr);
    check({irq_cond, brn_cond, wait_cond} === {exp_cond(0), exp_cond(1), exp_cond(2)},
          "R8 conditions", {29'h0, irq_cond, brn_cond, wait_cond},
          {29'h0, exp_cond(0), exp_cond(1), exp_cond(2)});
  endtask

  // one cycle: drive at negedge, check read, clock, check state
  task automatic step(input bit we, input int a, input logic [31:0] d,
                      input logic [7:0] hen, input logic [7:0] hval);
    logic [31:0] er;
    reg_we = we; reg_addr = 4'(a); reg_wdata = d;
    dev_set_en = hen; dev_set_val = hval;
    #1;
    er = exp_read(a);
    if (a == 1)                check(reg_rdata === er, "R3 status read", reg_rdata, er);
    else if (a >= 4 && a <= 6) check(reg_rdata === er, "R7 selector read", reg_rdata, er);
    else if (a == 2 || a == 3) check(reg_rdata === er, "R6 pointer read", reg_rdata, er);
    else                       check(reg_rdata === er, "R9 unmapped read", reg_rdata, er);
    @(posedge clk);
    model_update(we, a, d, hen, hval);
    @(negedge clk);
    reg_we = 1'b0; dev_set_en = '0;
    check_outputs();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20081030));
    m_ctl = '0; m_ptr = '0; m_hi = '0;
    for (int k = 0; k < 3; k++) begin m_smask[k] = '0; m_sval[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, conditions all match on zero selectors
    check(status_o === 16'h0, "R1 reset status", {16'h0, status_o}, 32'h0);
    check(cmd_ptr_o === 32'h0 && cmd_ptr_hi_o === 32'h0, "R1 reset pointers", cmd_ptr_o, 32'h0);
    check({irq_cond, brn_cond, wait_cond} === 3'b111, "R1 reset conditions",
          {29'h0, irq_cond, brn_cond, wait_cond}, 32'h7);

    // R2/R4: start channel, ACTIVE follows
    step(1, 0, 32'hFFFF_8000, 8'h00, 8'h00);
    check(status_o === 16'h8400, "R4 run sets active", {16'h0, status_o}, 32'h8400);
    step(1, 0, 32'h0400_0000, 8'h00, 8'h00);  // R4 ACTIVE not writable
    check(status_o === 16'h8400, "R4 active read-only", {16'h0, status_o}, 32'h8400);
    step(1, 0, 32'h4000_4000, 8'h00, 8'h00);
    check(status_o === 16'hC000, "R4 pause clears active", {16'h0, status_o}, 32'hC000);
    step(1, 0, 32'hC000_8000, 8'h00, 8'h00);
    step(1, 0, 32'h8000_0000, 8'h00, 8'h00);
    check(status_o[10] === 1'b0, "R4 run clear drops active", {31'h0, status_o[10]}, 32'h0);
    // R2: reserved bits ignored, unmasked bits kept
    step(1, 0, 32'h03FF_03AA, 8'h00, 8'h00);
    check(status_o === 16'h00AA, "R2 masked write", {16'h0, status_o}, 32'h00AA);
    // R5: same-cycle collision on low nibble
    step(1, 0, 32'h00FF_0055, 8'h0F, 8'h0A);
    check(status_o[7:0] === 8'h5A, "R5 hardware priority", {24'h0, status_o[7:0]}, 32'h5A);
    // R6: alignment
    step(1, 3, 32'h1234_567F, 8'h00, 8'h00);
    check(cmd_ptr_o === 32'h1234_5670, "R6 aligned pointer", cmd_ptr_o, 32'h1234_5670);
    step(1, 2, 32'hDEAD_BEEF, 8'h00, 8'h00);
    // R7/R8: selector match and miss
    step(1, 4, 32'hFF0F_FF0A, 8'h00, 8'h00);
    step(0, 4, 32'h0, 8'h00, 8'h00);
    check(irq_cond === 1'b1, "R8 irq match", {31'h0, irq_cond}, 32'h1);
    step(1, 5, 32'h0080_0080, 8'h00, 8'h00);
    check(brn_cond === 1'b0, "R8 branch miss", {31'h0, brn_cond}, 32'h0);
    // R9: ignored writes
    step(1, 1, 32'hFFFF_FFFF, 8'h00, 8'h00);
    step(1, 9, 32'hFFFF_FFFF, 8'h00, 8'h00);
    step(0, 0, 32'h0, 8'h00, 8'h00);
    step(0, 15, 32'h0, 8'h00, 8'h00);

    for (int n = 0; n < 2000; n++) begin
      bit we;
      int a;
      logic [31:0] d;
      logic [7:0] hen;
      we  = ($urandom % 3) != 0;
      a   = $urandom % 16;
      d   = $urandom;
      if (($urandom % 4) == 0) a = 0;
      hen = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
      step(we, a, d, hen, 8'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule